// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces auto-refresh requests for an SDRAM controller. A dynamic memory of 8192 rows that must be fully refreshed every 64 ms needs one refresh command every 7.8125 µs. In clock cycles that interval is 64000 × f(MHz) / 8192. At a 400 MHz memory clock this gives 3125 cycles. Software programs this interval and the timer counts it out. Each time it expires, the timer adds refreshes to an owed count. It holds a request high until the command generator has acknowledged every owed refresh.

Two pacing modes exist. In single mode, each programmed interval adds one owed refresh. In burst mode, the timer counts eight intervals back to back and then adds eight owed refreshes at once. The controller can then issue them together and spend longer stretches with no refresh interruptions. The interval counter never stops while refreshes are pending, so a slow acknowledge path does not stretch the average refresh rate. The owed count saturates at sixteen. If a refresh would be lost to that limit, a sticky overflow flag is raised. Dropping the enable clears the whole timer.

Top module: `refresh_pacer`

## Requirements
- R1: After reset, `owed` is 0 and `refReq` and `overflow` are low.
- R2: With `enable` high and `burstMode` low, `owed` rises by one at the clock edge that completes each run of `interval` enabled cycles. The first rise comes at the `interval`-th rising edge after `enable` is first sampled high.
- R3: With `burstMode` high, the period is 8 × `interval` enabled cycles, and `owed` rises by eight at the edge that completes each period.
- R4: An `interval` of 0 or 1 makes the period a single cycle, so in single mode `owed` rises by one on every enabled edge.
- R5: `refReq` is high exactly when `owed` is non-zero.
- R6: A rising edge with `refAck` high and `owed` non-zero lowers `owed` by one. A `refAck` while `owed` is 0 has no effect.
- R7: The interval counter keeps running while refreshes are owed. When an expiry and an acknowledge land on the same edge, the additions and the removal are both applied.
- R8: While `enable` is low, the next edge clears the interval counter, `owed` and `overflow`. After `enable` returns high, a full period passes before the next rise.
- R9: `owed` never exceeds 16. An update that would take it past 16 leaves it at 16 and sets `overflow`. Reaching exactly 16 does not set `overflow`.
- R10: `overflow` stays set while `enable` is high, even after acknowledges lower `owed`. Without an acknowledge, `owed` never falls while `enable` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Refresh generation enable; low clears the timer |
| burstMode | input | 1 | 1 = burst pacing (eight intervals, eight refreshes), 0 = single pacing |
| interval | input | 16 | Single refresh interval in clock cycles |
| refAck | input | 1 | One refresh command was issued this cycle |
| refReq | output | 1 | Refresh requested (owed count non-zero) |
| owed | output | 5 | Number of refreshes owed, 0 to 16 |
| overflow | output | 1 | Sticky flag: a refresh was dropped at the saturation limit |

## Verification
The bench targets the off-by-one edges of the period. It samples one cycle before and exactly at the expected expiry in both modes. A counter that reloads one cycle late, or that multiplies the burst period wrongly, shows up as a count that is early or late by one.

Saturation is probed at the boundary. A count landing exactly on sixteen must not flag overflow, while seventeen single expiries and a triple burst must both clamp and flag. A design that wraps the count or compares against the wrong limit reports a small count or a clear flag.

The acknowledge paths are checked for three cases. An acknowledge at zero must not wrap the count. An expiry coinciding with an acknowledge must leave the count unchanged. A timer that paused while refreshes were pending would deliver its next expiry late.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;

  // Strobes from the interval control to the owed-count datapath
  typedef struct packed {
    logic clear;   // enable low: wipe the count and the flag
    logic expire;  // the current period completed on this edge
    logic burst;   // the completed period was a burst period
    logic take;    // an acknowledge is consumed on this edge
  } pacerStrobe_t;

endpackage

// File: rtl/refresh_pacer_ctrl.sv
module refresh_pacer_ctrl
  import refresh_pacer_pkg::*;
#(
  parameter int INTERVAL_W = 16,
  parameter int BURST_LEN  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  burstMode,
  input  logic [INTERVAL_W-1:0] interval,
  input  logic                  refAck,
  input  logic                  owedNonZero,
  output pacerStrobe_t          strobe
);

  localparam int PERIOD_W = INTERVAL_W + $clog2(BURST_LEN);

  logic [PERIOD_W-1:0] tick;
  logic [PERIOD_W-1:0] period;
  logic [PERIOD_W:0]   tickInc;
  logic                lastTick;

  // Period length for the selected pacing mode
  always_comb begin
    if (burstMode) period = PERIOD_W'(interval) * PERIOD_W'(BURST_LEN);
    else           period = PERIOD_W'(interval);
  end

  // Periods of 0 or 1 both complete on every cycle
  always_comb begin
    tickInc  = {1'b0, tick} + 1'b1;
    lastTick = tickInc >= {1'b0, period};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          tick <= '0;
    else if (!enable)   tick <= '0;
    else if (lastTick)  tick <= '0;
    else                tick <= tickInc[PERIOD_W-1:0];
  end

  always_comb begin
    strobe.clear  = !enable;
    strobe.expire = enable && lastTick;
    strobe.burst  = burstMode;
    strobe.take   = enable && refAck && owedNonZero;
  end

endmodule

// File: rtl/refresh_pacer_dp.sv
module refresh_pacer_dp
  import refresh_pacer_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int MAX_OWED  = 16,
  parameter int OWED_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pacerStrobe_t      strobe,
  output logic [OWED_W-1:0] owed,
  output logic              owedNonZero,
  output logic              overflow
);

  localparam int SUM_W = OWED_W + $clog2(BURST_LEN) + 1;

  logic [SUM_W-1:0] addAmt;
  logic [SUM_W-1:0] nextSum;
  logic             saturate;

  always_comb begin
    if (!strobe.expire)    addAmt = '0;
    else if (strobe.burst) addAmt = SUM_W'(BURST_LEN);
    else                   addAmt = SUM_W'(1);
    // take is only asserted with a non-zero count, so no underflow
    nextSum  = SUM_W'(owed) + addAmt - (strobe.take ? SUM_W'(1) : SUM_W'(0));
    saturate = nextSum > SUM_W'(MAX_OWED);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      owed     <= '0;
      overflow <= 1'b0;
    end else begin
      owed     <= saturate ? OWED_W'(MAX_OWED) : nextSum[OWED_W-1:0];
      overflow <= overflow | saturate;
    end
  end

  assign owedNonZero = |owed;

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int INTERVAL_W = 16,
  parameter int BURST_LEN  = 8,
  parameter int MAX_OWED   = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              enable,
  input  logic                              burstMode,
  input  logic [INTERVAL_W-1:0]             interval,
  input  logic                              refAck,
  output logic                              refReq,
  output logic [$clog2(MAX_OWED+1)-1:0]     owed,
  output logic                              overflow
);

  localparam int OWED_W = $clog2(MAX_OWED + 1);

  pacerStrobe_t strobe;
  logic         owedNonZero;

  refresh_pacer_ctrl #(
    .INTERVAL_W(INTERVAL_W),
    .BURST_LEN (BURST_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .burstMode  (burstMode),
    .interval   (interval),
    .refAck     (refAck),
    .owedNonZero(owedNonZero),
    .strobe     (strobe)
  );

  refresh_pacer_dp #(
    .BURST_LEN(BURST_LEN),
    .MAX_OWED (MAX_OWED),
    .OWED_W   (OWED_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .owed       (owed),
    .owedNonZero(owedNonZero),
    .overflow   (overflow)
  );

  assign refReq = owedNonZero;

endmodule

// File: rtl/refresh_pacer_chk.sv
module refresh_pacer_chk #(
  parameter int OWED_W    = 5,
  parameter int MAX_OWED  = 16,
  parameter int BURST_LEN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              refAck,
  input logic              refReq,
  input logic [OWED_W-1:0] owed,
  input logic              overflow
);

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (owed == '0) && !overflow);

  // R9
  owed_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(owed) <= MAX_OWED);

  // R9
  overflow_at_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> int'(owed) == MAX_OWED);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && enable |=> overflow);

  // R10
  no_drop_without_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && !refAck |=> int'(owed) >= int'($past(owed)));

  // R3
  bounded_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> int'(owed) <= int'($past(owed)) + BURST_LEN);

  // R6
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && !refReq && refAck |=> int'(owed) <= BURST_LEN);

endmodule

bind refresh_pacer refresh_pacer_chk #(
  .OWED_W   (OWED_W),
  .MAX_OWED (MAX_OWED),
  .BURST_LEN(BURST_LEN)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .refAck  (refAck),
  .refReq  (refReq),
  .owed    (owed),
  .overflow(overflow)
);

// File: tb/refresh_pacer_tb.sv
`timescale 1ns/1ps
module refresh_pacer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        burstMode = 1'b0;
  logic [15:0] interval = 16'd0;
  logic        refAck = 1'b0;
  logic        refReq;
  logic [4:0]  owed;
  logic        overflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  refresh_pacer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .burstMode(burstMode),
    .interval(interval), .refAck(refAck), .refReq(refReq),
    .owed(owed), .overflow(overflow)
  );

  typedef struct packed {
    logic        burst;
    logic [15:0] ivl;
    logic [15:0] waitEdges;
    logic [4:0]  expOwed;
    logic        expOvf;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'd10, 16'd9,  5'd0,  1'b0},  // R2 one edge early
    '{1'b0, 16'd10, 16'd10, 5'd1,  1'b0},  // R2 first expiry
    '{1'b0, 16'd10, 16'd30, 5'd3,  1'b0},  // R2 R7 three periods
    '{1'b1, 16'd4,  16'd31, 5'd0,  1'b0},  // R3 one edge early
    '{1'b1, 16'd4,  16'd32, 5'd8,  1'b0},  // R3 one burst
    '{1'b1, 16'd4,  16'd64, 5'd16, 1'b0},  // R3 R9 exactly at limit
    '{1'b0, 16'd0,  16'd5,  5'd5,  1'b0},  // R4 zero interval
    '{1'b0, 16'd1,  16'd3,  5'd3,  1'b0},  // R4 unit interval
    '{1'b1, 16'd2,  16'd48, 5'd16, 1'b1},  // R9 three bursts clamp
    '{1'b0, 16'd3,  16'd51, 5'd16, 1'b1}   // R9 seventeen singles clamp
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic b, input logic [15:0] ivl);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    burstMode = b;
    interval  = ivl;
    enable    = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 owed", owed, 0);
    chk("R1 refReq", refReq, 0);
    chk("R1 overflow", overflow, 0);

    // Table: R2 R3 R4 R5 R9
    for (int i = 0; i < NVEC; i++) begin
      restart(VECS[i].burst, VECS[i].ivl);
      repeat (int'(VECS[i].waitEdges)) @(negedge clk);
      chk($sformatf("R2/R3/R4/R9 vec%0d owed", i), owed, int'(VECS[i].expOwed));
      chk($sformatf("R9 vec%0d overflow", i), overflow, int'(VECS[i].expOvf));
      chk($sformatf("R5 vec%0d refReq", i), refReq, int'(VECS[i].expOwed != 0));
    end

    // R6 R7 acknowledge handling, interval 5
    restart(1'b0, 16'd5);
    repeat (15) @(negedge clk);
    chk("R2 owed before ack", owed, 3);
    refAck = 1'b1;
    @(negedge clk);
    chk("R6 one ack", owed, 2);
    chk("R5 req while owed", refReq, 1);
    repeat (2) @(negedge clk);
    chk("R6 drained", owed, 0);
    chk("R5 req low at zero", refReq, 0);
    @(negedge clk);
    chk("R6 ack at zero ignored", owed, 0);
    refAck = 1'b0;
    @(negedge clk);
    chk("R7 counter kept running", owed, 1);
    repeat (4) @(negedge clk);
    chk("R7 holds between expiries", owed, 1);
    refAck = 1'b1;
    @(negedge clk);
    chk("R7 expiry with ack", owed, 1);
    refAck = 1'b0;

    // R10 sticky overflow, then R8 clear
    restart(1'b1, 16'd2);
    repeat (48) @(negedge clk);
    chk("R9 clamp", owed, 16);
    refAck = 1'b1;
    @(negedge clk);
    refAck = 1'b0;
    chk("R10 ack below limit", owed, 15);
    chk("R10 overflow sticky", overflow, 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 owed cleared", owed, 0);
    chk("R8 overflow cleared", overflow, 0);
    chk("R8 req cleared", refReq, 0);
    burstMode = 1'b0;
    interval  = 16'd6;
    enable    = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 full period after re-enable", owed, 0);
    @(negedge clk);
    chk("R8 first expiry after re-enable", owed, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule